// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block gathers 64 interrupt request lines and decides which one the processor should see. Software gives every source a 3-bit priority level, a mask bit and a force bit. A source takes part when it is pending or forced, it is not masked, and its level is not zero. Among those sources, the one with the highest level wins. When several share that level, the highest source number wins.

The winning level goes to the processor only when level gating is off, or when the level is strictly above the processor's current mask level. The winning level and source index are registered, so they follow the inputs one clock later.

When the processor takes the interrupt, it reads an acknowledge vector for a chosen level. The read returns 64 plus the highest-numbered active source at that level. When no active source sits at that level, it returns a spurious code.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF, both force words read 0, every level field reads 0, and irq_lvl_o and irq_src_o are 0.
- R2: Register map on cfg_addr, written when cfg_we is high at a clock edge and read combinationally on cfg_rdata:
  - address 0 holds mask bits 31..0 and address 1 holds mask bits 63..32;
  - address 2 holds force bits 31..0 and address 3 holds force bits 63..32;
  - address 64+n holds the level of source n in data bits 2..0, and the other bits read 0.
- R3: A source whose level field is 0 never wins and never answers an acknowledge.
- R4: Among active sources at the same level, the highest source number wins.
- R5: A source at a higher level wins over any source at a lower level, whatever their numbers.
- R6: A set mask bit (1 = masked) blocks its source, whether the source is pending or forced.
- R7: A set force bit makes an unmasked source active even when its pending input is low.
- R8: With gate_en high, the winner is presented only when its level is strictly greater than cpu_mask_lvl. Otherwise irq_lvl_o and irq_src_o are 0. With gate_en low, the winner is always presented.
- R9: ack_vec_o is combinational in ack_lvl. It equals 64 + n, where n is the highest-numbered active source whose level equals ack_lvl. When there is no such source, or ack_lvl is 0, it is 0x18. It does not depend on cpu_mask_lvl or gate_en.
- R10: irq_lvl_o and irq_src_o follow a change of irq_pend, cpu_mask_lvl or gate_en after exactly one rising clock edge. They follow a register write one edge after the write edge.
- R11: For any mix of pending, mask, force and level settings, the presented level and source match a level-then-number arbitration followed by mask-level gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 64 | Raw pending request per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| cpu_mask_lvl | input | 3 | Processor's current interrupt mask level |
| gate_en | input | 1 | Enables mask-level gating |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_vec_o | output | 8 | Acknowledge vector |
| irq_lvl_o | output | 3 | Presented priority level, 0 = none |
| irq_src_o | output | 6 | Presented winning source, 0 when none |

## Verification
The bench drives inputs on the falling edge.

- **Arbitration outputs:** a change on irq_pend, cpu_mask_lvl or gate_en is due on irq_lvl_o and irq_src_o at the next falling edge, one rising edge later. The bench also samples just after the change to confirm the old value still holds.
- **Register writes:** the write edge is followed by one more edge before the bench compares.
- **Acknowledge vector and register reads:** both are combinational, so the bench samples them a moment after driving ack_lvl or cfg_addr, with no clock edge in between.
- **Expected values:** these come from bench functions over shadow copies of everything the bench has written.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC     = 64,
  parameter int LW       = 3,
  parameter int AW       = 7,
  parameter int DW       = 32,
  parameter int VW       = 8,
  parameter int LVL_BASE = 64,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_pend,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic [LW-1:0]   cpu_mask_lvl,
  input  logic            gate_en,
  input  logic [LW-1:0]   ack_lvl,
  output logic [VW-1:0]   ack_vec_o,
  output logic [LW-1:0]   irq_lvl_o,
  output logic [$clog2(NSRC)-1:0] irq_src_o
);
  localparam int SW    = $clog2(NSRC);
  localparam int NWORD = NSRC / DW;

  logic [NSRC-1:0] mask_q, force_q, act;
  logic [LW-1:0]   lvl_q [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      force_q <= '0;
      lvl_q   <= '{default: '0};
    end else if (cfg_we) begin
      for (int w = 0; w < NWORD; w++) begin
        if (cfg_addr == AW'(w))         mask_q[w*DW +: DW]  <= cfg_wdata;
        if (cfg_addr == AW'(NWORD + w)) force_q[w*DW +: DW] <= cfg_wdata;
      end
      for (int s = 0; s < NSRC; s++)
        if (cfg_addr == AW'(LVL_BASE + s)) lvl_q[s] <= cfg_wdata[LW-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (cfg_addr == AW'(w))         cfg_rdata = mask_q[w*DW +: DW];
      if (cfg_addr == AW'(NWORD + w)) cfg_rdata = force_q[w*DW +: DW];
    end
    for (int s = 0; s < NSRC; s++)
      if (cfg_addr == AW'(LVL_BASE + s)) cfg_rdata = DW'(lvl_q[s]);
  end

  assign act = (irq_pend | force_q) & ~mask_q;

  logic [LW-1:0] best_l;
  logic [SW-1:0] best_s;
  logic          ack_hit;
  logic [SW-1:0] ack_s;

  always_comb begin
    best_l  = '0;
    best_s  = '0;
    ack_hit = 1'b0;
    ack_s   = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (act[s] && lvl_q[s] != '0 && lvl_q[s] >= best_l) begin
        best_l = lvl_q[s];
        best_s = SW'(s);
      end
      if (act[s] && ack_lvl != '0 && lvl_q[s] == ack_lvl) begin
        ack_hit = 1'b1;
        ack_s   = SW'(s);
      end
    end
  end

  wire pass = (best_l != '0) && (!gate_en || best_l > cpu_mask_lvl);

  assign ack_vec_o = ack_hit ? VW'(VEC_BASE) + VW'(ack_s) : VW'(VEC_SPUR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lvl_o <= '0;
      irq_src_o <= '0;
    end else begin
      irq_lvl_o <= pass ? best_l : '0;
      irq_src_o <= pass ? best_s : '0;
    end
  end

  AST_GATE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_o != '0 && $past(gate_en)) |-> irq_lvl_o > $past(cpu_mask_lvl)); // R8
  AST_IDLE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_o == '0) |-> irq_src_o == '0); // R8
  AST_WIN_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_o != '0 && !$past(cfg_we)) |-> lvl_q[irq_src_o] == irq_lvl_o); // R3
  AST_ACK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vec_o == VW'(VEC_SPUR) || (ack_vec_o >= VW'(VEC_BASE) && ack_vec_o < VW'(VEC_BASE + NSRC))); // R9
  AST_ACK_SOURCE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec_o != VW'(VEC_SPUR)) |-> (act[SW'(ack_vec_o - VW'(VEC_BASE))]
      && lvl_q[SW'(ack_vec_o - VW'(VEC_BASE))] == ack_lvl)); // R6
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  logic        clk = 0, rst_n = 0;
  logic [63:0] irq_pend = '0;
  logic        cfg_we = 0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [2:0]  cpu_mask_lvl = '0, ack_lvl = '0, irq_lvl_o;
  logic        gate_en = 0;
  logic [7:0]  ack_vec_o;
  logic [5:0]  irq_src_o;

  always #2.5 clk = ~clk;

  irq_level_arbiter u_irq_level_arbiter (.*);

  int n_chk = 0, n_bad = 0;
  logic [2:0]  sh_lvl [64];
  logic [63:0] sh_mask, sh_force;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] active();
    return (irq_pend | sh_force) & ~sh_mask;
  endfunction

  function automatic logic [8:0] ref_win();
    logic [63:0] a = active();
    logic [2:0] bl = 0; logic [5:0] bs = 0;
    for (int s = 0; s < 64; s++)
      if (a[s] && sh_lvl[s] != 0 && sh_lvl[s] >= bl) begin bl = sh_lvl[s]; bs = 6'(s); end
    if (gate_en && bl <= cpu_mask_lvl) begin bl = 0; bs = 0; end
    return {bl, bs};
  endfunction

  function automatic logic [7:0] ref_ack(logic [2:0] l);
    logic [63:0] a = active();
    logic [7:0] v = 8'h18;
    if (l != 0)
      for (int s = 0; s < 64; s++)
        if (a[s] && sh_lvl[s] == l) v = 8'(64 + s);
    return v;
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 0) sh_mask[31:0] = d;
    if (a == 1) sh_mask[63:32] = d;
    if (a == 2) sh_force[31:0] = d;
    if (a == 3) sh_force[63:32] = d;
    if (a >= 64) sh_lvl[a - 64] = d[2:0];
  endtask

  task automatic set_lvl(int s, logic [2:0] l); wr(7'(64 + s), 32'(l)); endtask
  task automatic set_mask(logic [63:0] m); wr(0, m[31:0]); wr(1, m[63:32]); endtask
  task automatic set_force(logic [63:0] f); wr(2, f[31:0]); wr(3, f[63:32]); endtask

  task automatic step_chk(string req);
    logic [8:0] e;
    e = ref_win();
    @(negedge clk);
    chk(req, 32'(irq_lvl_o), 32'(e[8:6]));
    chk(req, 32'(irq_src_o), 32'(e[5:0]));
  endtask

  task automatic ack_chk(string req, logic [2:0] l);
    ack_lvl = l; #0.5;
    chk(req, 32'(ack_vec_o), 32'(ref_ack(l)));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    sh_mask = '1; sh_force = '0;
    for (int s = 0; s < 64; s++) sh_lvl[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cfg_addr = 0; #0.5; chk("R1", cfg_rdata, 32'hFFFFFFFF);
    cfg_addr = 1; #0.5; chk("R1", cfg_rdata, 32'hFFFFFFFF);
    cfg_addr = 3; #0.5; chk("R1", cfg_rdata, 0);
    cfg_addr = 7'd100; #0.5; chk("R1", cfg_rdata, 0);
    chk("R1", 32'(irq_lvl_o), 0);
    chk("R1", 32'(irq_src_o), 0);

    // R2 readback
    set_lvl(5, 3'd6);
    cfg_addr = 7'd69; #0.5; chk("R2", cfg_rdata, 6);
    wr(2, 32'h0000_0100);
    cfg_addr = 2; #0.5; chk("R2", cfg_rdata, 32'h100);
    set_force('0);

    // R3: pending but level 0
    set_mask('0);
    irq_pend = 64'h1; step_chk("R3");
    chk("R3", 32'(irq_lvl_o), 0);
    ack_chk("R3", 3'd0);

    // R4 tie within level 3
    foreach (sh_lvl[i]) ;
    set_lvl(40, 3); set_lvl(22, 3); set_lvl(8, 3); set_lvl(2, 3);
    irq_pend = (64'h1 << 40) | (64'h1 << 22) | (64'h1 << 8) | (64'h1 << 2);
    step_chk("R4");
    chk("R4", 32'(irq_src_o), 40);
    irq_pend[40] = 0; step_chk("R4");
    chk("R4", 32'(irq_src_o), 22);
    ack_chk("R9", 3'd3);
    chk("R9", 32'(ack_vec_o), 64 + 22);
    ack_chk("R9", 3'd5);
    chk("R9", 32'(ack_vec_o), 8'h18);

    // R5 higher level wins over higher number
    set_lvl(2, 5); step_chk("R5");
    chk("R5", 32'(irq_src_o), 2);

    // R6 mask blocks pending and force
    set_mask(64'h4); step_chk("R6");
    chk("R6", 32'(irq_src_o), 22);
    set_force(64'h4); step_chk("R6");
    ack_chk("R6", 3'd5);

    // R7 force with no pending
    set_mask('0); irq_pend = '0; set_force(64'h1 << 8);
    step_chk("R7");
    chk("R7", 32'(irq_src_o), 8);

    // R8 gating strictly greater
    gate_en = 1; cpu_mask_lvl = 3; step_chk("R8");
    chk("R8", 32'(irq_lvl_o), 0);
    cpu_mask_lvl = 2; step_chk("R8");
    chk("R8", 32'(irq_lvl_o), 3);
    ack_chk("R9", 3'd3);
    gate_en = 0; cpu_mask_lvl = 7; step_chk("R8");

    // R10 latency
    @(negedge clk); irq_pend = 64'h1 << 22; set_force('0);
    @(negedge clk); chk("R10", 32'(irq_src_o), 22);
    irq_pend = 64'h1 << 40; #0.5;
    chk("R10", 32'(irq_src_o), 22);
    @(negedge clk); chk("R10", 32'(irq_src_o), 40);

    // R11 random
    void'($urandom(32'd7));
    for (int s = 0; s < 64; s++) set_lvl(s, 3'($urandom));
    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < 3; k++) set_lvl(int'($urandom % 64), 3'($urandom));
      if (t % 4 == 0) set_mask({$urandom, $urandom} & {$urandom, $urandom});
      if (t % 5 == 0) set_force({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      irq_pend = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cpu_mask_lvl = 3'($urandom);
      gate_en = 1'($urandom);
      step_chk("R11");
      ack_chk("R11", 3'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule